// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block is the interrupt logic of a 16550-style serial port. It gathers the pending interrupt sources, which are line-status errors, a receive character timeout, received data, an empty transmit holding register and modem-status changes. It masks each source with a stored four-bit enable register and reports the single highest-priority source as an identification code. A level interrupt output is raised whenever any enabled source is pending.

The serial shifters, FIFOs and baud logic sit outside the block and feed it as plain status inputs. The block keeps two pieces of state. The first is the enable register. The second is the transmit-empty pending flag, which register accesses set and clear. Reading the identification register while it reports transmit-empty acknowledges that source. Writing the enable register while the holding register is empty arms it again. Writing the holding register clears it.

Top module: `uart_irq_prio`

## Requirements
- R1: Sources are ranked, highest first: line-status error (any bit of `lsr_err` set, enabled by enable bit 2), character timeout, received data, transmit holding empty (enable bit 1), modem-status change (any bit of `msr_delta` set, enabled by enable bit 3). Only the highest enabled pending source is reported.
- R2: `iir_q[3:0]` is 0x1 with nothing pending, 0x6 for line status, 0xC for timeout, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem status. Bits 5:4 read 0.
- R3: `iir_q[7:6]` reads 11 when `fifo_en` is high and 00 when it is low, whatever the code.
- R4: The character timeout is enabled by enable bit 0, the same bit that enables received data.
- R5: With `fifo_en` high, received data is reported only when `data_ready` is high and `rx_count` is at or above the trigger level. `rx_trig` selects the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With `fifo_en` low, `data_ready` alone reports it.
- R6: A pulse on `iir_rd` while the code is 0x2 clears the transmit-empty pending flag from the next cycle. A read while another code is shown leaves the flag unchanged.
- R7: A pulse on `ier_wr` stores `ier_wdata[3:0]` into `ier_q` and ignores the upper bits. If `thr_empty` is high in that cycle, the transmit-empty pending flag is set.
- R8: A pulse on `thr_wr` clears the transmit-empty pending flag.
- R9: A pulse on `thre_event` sets the pending flag. It wins over a same-cycle identification read or holding-register write.
- R10: After reset `ier_q` is 0, the flag is clear and `iir_q` reads 0x01 (with `fifo_en` low).
- R11: `irq` is high in the same cycle that the code differs from 0x1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| iir_rd | input | 1 | Identification-register read strobe |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_empty | input | 1 | Holding register currently empty |
| thre_event | input | 1 | Transmitter just emptied (pulse) |
| fifo_en | input | 1 | FIFO mode active |
| rx_trig | input | 2 | Receive trigger-level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| data_ready | input | 1 | Received data available |
| lsr_err | input | 4 | Overrun, parity, framing, break flags |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem-status change bits |
| ier_q | output | 4 | Stored enable register |
| iir_q | output | 8 | Identification register value |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are the ones where the transmit-empty pending flag must survive an access that normally changes it. One case is a read of the identification register while a higher-priority line error hides the transmit code. The other is a transmitter-empty pulse that arrives in the same cycle as the acknowledging read. The bench first arms the flag, then raises a line error and issues the read. It then removes the error, so that the surviving flag shows up in the code. Separately, it drives the event and the read on the same edge while code 0x2 is showing.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             thr_empty,
  input  logic             thre_event,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             data_ready,
  input  logic [3:0]       lsr_err,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier_q,
  output logic [7:0]       iir_q,
  output logic             irq
);

  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TOUT = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_TXE  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  localparam int LVL0 = 1;
  localparam int LVL1 = FIFO_DEPTH / 4;
  localparam int LVL2 = FIFO_DEPTH / 2;
  localparam int LVL3 = FIFO_DEPTH - 2;

  logic             thr_pend;
  logic [3:0]       code;
  logic [CNT_W-1:0] trig_lvl;
  logic             rx_src;

  always_comb begin
    case (rx_trig)
      2'd0:    trig_lvl = CNT_W'(LVL0);
      2'd1:    trig_lvl = CNT_W'(LVL1);
      2'd2:    trig_lvl = CNT_W'(LVL2);
      default: trig_lvl = CNT_W'(LVL3);
    endcase
  end

  assign rx_src = data_ready && (!fifo_en || rx_count >= trig_lvl);

  always_comb begin
    if (ier_q[2] && |lsr_err)           code = ID_LINE;
    else if (ier_q[0] && timeout_pend)  code = ID_TOUT;
    else if (ier_q[0] && rx_src)        code = ID_RXD;
    else if (ier_q[1] && thr_pend)      code = ID_TXE;
    else if (ier_q[3] && |msr_delta)    code = ID_MDM;
    else                                code = ID_NONE;
  end

  assign iir_q = {{2{fifo_en}}, 2'b00, code};
  assign irq   = code != ID_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          thr_pend <= 1'b0;
    else if (thre_event)                 thr_pend <= 1'b1;
    else if (ier_wr && thr_empty)        thr_pend <= 1'b1;
    else if (thr_wr)                     thr_pend <= 1'b0;
    else if (iir_rd && code == ID_TXE)   thr_pend <= 1'b0;
  end

  AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && |lsr_err) |-> iir_q[3:0] == ID_LINE);                         // R1
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'h0) |-> !irq);                                                 // R11
  AST_IER_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q == $past(ier_wdata[3:0]));                                // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thr_empty) |=> thr_pend);                                       // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    thre_event |=> thr_pend);                                                  // R9
  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thre_event && !(ier_wr && thr_empty)) |=> !thr_pend);          // R8
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_q[3:0] == ID_TXE && !thre_event && !(ier_wr && thr_empty))
      |=> !thr_pend);                                                          // R6

endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, iir_rd = 0, thr_wr = 0, thr_empty = 0, thre_event = 0;
  logic [7:0] ier_wdata = 0;
  logic fifo_en = 0, data_ready = 0, timeout_pend = 0;
  logic [1:0] rx_trig = 0;
  logic [CW-1:0] rx_count = 0;
  logic [3:0] lsr_err = 0, msr_delta = 0;
  logic [3:0] ier_q;
  logic [7:0] iir_q;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_prio u0 (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .thr_empty(thr_empty),
    .thre_event(thre_event), .fifo_en(fifo_en), .rx_trig(rx_trig),
    .rx_count(rx_count), .data_ready(data_ready), .lsr_err(lsr_err),
    .timeout_pend(timeout_pend), .msr_delta(msr_delta),
    .ier_q(ier_q), .iir_q(iir_q), .irq(irq));

  // {ier[30:27], err[26:23], tout[22], dr[21], fe[20], trig[19:18], cnt[17:13], msr[12:9], thr[8], exp[7:0]}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {4'hF, 4'h2, 1'b1, 1'b1, 1'b1, 2'd0, 5'd1,  4'h1, 1'b1, 8'hC6}, // R1 R2 line top
    {4'hB, 4'h2, 1'b1, 1'b1, 1'b1, 2'd0, 5'd1,  4'h1, 1'b1, 8'hCC}, // R1 timeout
    {4'hE, 4'h0, 1'b1, 1'b1, 1'b1, 2'd0, 5'd1,  4'h0, 1'b1, 8'hC2}, // R4 timeout masked
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b1, 2'd1, 5'd3,  4'h0, 1'b1, 8'hC2}, // R5 below level 4
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b1, 2'd1, 5'd4,  4'h0, 1'b1, 8'hC4}, // R5 at level 4
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b1, 2'd3, 5'd13, 4'h1, 1'b0, 8'hC0}, // R5 below 14, modem
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b1, 2'd3, 5'd14, 4'h1, 1'b0, 8'hC4}, // R5 at 14
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b0, 2'd3, 5'd0,  4'h0, 1'b1, 8'h04}, // R5 non-fifo
    {4'h8, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0,  4'h2, 1'b1, 8'h00}, // R2 modem
    {4'h0, 4'hF, 1'b1, 1'b1, 1'b0, 2'd0, 5'd9,  4'hF, 1'b1, 8'h01}, // R11 all masked
    {4'h7, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0,  4'hF, 1'b0, 8'h01}, // R1 modem masked
    {4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd0,  4'h0, 1'b1, 8'h02}, // R2 tx empty
    {4'h4, 4'h8, 1'b0, 1'b0, 1'b1, 2'd0, 5'd0,  4'h0, 1'b0, 8'hC6}, // R2 R3 break
    {4'h1, 4'h0, 1'b0, 1'b1, 1'b1, 2'd2, 5'd8,  4'h0, 1'b0, 8'hC4}, // R5 at 8
    {4'h1, 4'h0, 1'b0, 1'b1, 1'b1, 2'd2, 5'd7,  4'h0, 1'b0, 8'hC1}, // R5 below 8
    {4'h1, 4'h0, 1'b0, 1'b1, 1'b1, 2'd0, 5'd1,  4'h0, 1'b0, 8'hC4}  // R5 at 1
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic pulse_ier(input logic [7:0] d);
    @(negedge clk); ier_wdata = d; ier_wr = 1;
    @(negedge clk); ier_wr = 0;
  endtask

  task automatic pulse_event();
    @(negedge clk); thre_event = 1;
    @(negedge clk); thre_event = 0;
  endtask

  task automatic pulse_thr();
    @(negedge clk); thr_wr = 1;
    @(negedge clk); thr_wr = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); iir_rd = 1;
    @(negedge clk); iir_rd = 0;
  endtask

  task automatic quiet();
    lsr_err = 0; timeout_pend = 0; data_ready = 0; msr_delta = 0; rx_count = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    check("R10 ier after reset", {4'h0, ier_q}, 8'h00);
    check("R10 iir after reset", iir_q, 8'h01);
    check("R10 irq after reset", {7'h0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      quiet();
      thr_empty = 0;
      pulse_ier({4'h0, v[30:27]});
      if (v[8]) pulse_event(); else pulse_thr();
      lsr_err = v[26:23]; timeout_pend = v[22]; data_ready = v[21];
      fifo_en = v[20]; rx_trig = v[19:18]; rx_count = v[17:13]; msr_delta = v[12:9];
      #1;
      check($sformatf("R1 R2 R3 R4 R5 vector %0d iir", i), iir_q, v[7:0]);
      check($sformatf("R11 vector %0d irq", i), {7'h0, irq}, {7'h0, v[3:0] != 4'h1});
    end

    quiet(); fifo_en = 0;
    thr_empty = 0; pulse_ier(8'h00); pulse_thr();
    thr_empty = 1; pulse_ier(8'hFA);
    check("R7 low nibble stored", {4'h0, ier_q}, 8'h0A);
    #1 check("R7 rearm on empty", iir_q, 8'h02);

    pulse_rd();
    #1 check("R6 ack clears", iir_q, 8'h01);

    thr_empty = 0; pulse_ier(8'h02);
    #1 check("R7 no rearm when full", iir_q, 8'h01);

    pulse_ier(8'h06); pulse_event();
    lsr_err = 4'h1;
    #1 check("R6 line hides tx", iir_q, 8'h06);
    pulse_rd();
    lsr_err = 0;
    #1 check("R6 read at other code keeps flag", iir_q, 8'h02);

    @(negedge clk); iir_rd = 1; thre_event = 1;
    @(negedge clk); iir_rd = 0; thre_event = 0;
    #1 check("R9 event beats read", iir_q, 8'h02);

    pulse_thr();
    #1 check("R8 thr write clears", iir_q, 8'h01);

    pulse_ier(8'h04);
    @(negedge clk); lsr_err = 4'h4;
    #1 check("R11 irq same cycle", {7'h0, irq}, 8'h01);
    lsr_err = 0;
    #1 check("R11 irq drops", {7'h0, irq}, 8'h00);
    fifo_en = 1;
    #1 check("R3 fifo bits idle", iir_q, 8'hC1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule